// File: doc/BRIEF.md
# Split-Message Variable Node Update Unit

This unit computes the outgoing variable-to-check messages of one variable node in an LDPC decoder. The incoming check messages of the node are handled in two groups. The regular-edge messages arrive directly on this unit. The random-edge messages are summed by a separate programmable side, and only their partial sum comes back to this unit, through an exchange port. Each outgoing message to a regular-edge check node is the extrinsic sum. That is the intrinsic channel value plus the regular partial sum plus the random partial sum, minus the message that the destination check node sent. The result is saturated symmetrically to the message width.

The unit also exports its regular-only partial sum one cycle after the input is taken. The programmable side can then form the messages for the random edges and the other half of the split check-node update. A degree code selects how many regular slots are live. Slots that are not live are treated as zero. For the degree-two node type, the random partial sum is ignored, because that type has only staircase edges. The unit is a two-stage pipeline and can accept one node per cycle.

Top module: `vn_split_update`

## Requirements
- R1: After reset, `out_valid` and `reg_valid` are 0 until a node is accepted.
- R2: `deg_sel` selects the live regular slots. Code 0 (degree two) makes slots 0..1 live. Code 1 (degree four) makes slots 0..2 live. Codes 2 and 3 (maximum degree) make slots 0..4 live. Slot i of `reg_msgs` and `out_msgs` occupies bits [6i+5:6i].
- R3: One cycle after `in_valid`, `reg_valid` is 1 and `reg_sum` holds the 9-bit two's-complement sum of the live regular messages. The intrinsic value and the random sum are not part of it.
- R4: Two cycles after `in_valid`, `out_valid` is 1 and it is 0 one cycle after `in_valid`. At that point, each live slot i of `out_msgs` equals the saturated value of intrinsic + regular sum + random sum − message i.
- R5: `rnd_sum` is sampled only in the cycle in which `reg_valid` is 1. The values it has in other cycles do not affect the result.
- R6: For `deg_sel` 0, `rnd_sum` is ignored and counted as zero.
- R7: The input values on slots that are not live do not affect any output, and the output slots that are not live are 0.
- R8: Outputs saturate to the symmetric range [−31, 31]. The value −32 is never produced.
- R9: Nodes presented on consecutive cycles each produce their own correct results, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Node inputs valid this cycle |
| deg_sel | input | 2 | Node degree code |
| intr | input | 6 | Signed intrinsic channel value |
| reg_msgs | input | 30 | Five signed regular check messages, slot i at [6i+5:6i] |
| rnd_sum | input | 9 | Signed random-edge partial sum, given one cycle after in_valid |
| reg_valid | output | 1 | Regular partial sum valid |
| reg_sum | output | 9 | Signed regular partial sum |
| out_valid | output | 1 | Outgoing messages valid |
| out_msgs | output | 30 | Five signed outgoing messages, slot i at [6i+5:6i] |

## Verification
The bench sends small mixed-sign messages at each degree code. These show that the slot masking is right and that the subtraction leaves out each edge's own input. Large values are placed on slots that are not live, and a large random sum is given for degree two. Any leak of these values into the outputs would change them. All-maximum and all-minimum inputs drive the sum into both saturation rails, including the −32 corner. The random sum is driven with junk values outside its sampling cycle, and two nodes are sent back to back. Together these separate a wrong sampling time and cross-talk between pipeline stages from correct behaviour.

// File: rtl/vn_split_update.sv
module vn_split_update #(
  parameter int MSG_W = 6,
  parameter int SUM_W = 9,
  parameter int NREG  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              deg_sel,
  input  logic signed [MSG_W-1:0] intr,
  input  logic [NREG*MSG_W-1:0]   reg_msgs,
  input  logic signed [SUM_W-1:0] rnd_sum,
  output logic                    reg_valid,
  output logic signed [SUM_W-1:0] reg_sum,
  output logic                    out_valid,
  output logic [NREG*MSG_W-1:0]   out_msgs
);
  localparam int TW = SUM_W + 2;
  localparam int MAXV = (1 << (MSG_W - 1)) - 1;
  localparam logic signed [TW-1:0] HI = TW'(MAXV);
  localparam logic signed [TW-1:0] LO = -HI;
  localparam int LIVE_D2 = 2;
  localparam int LIVE_D4 = 3;

  int live_cnt;
  logic signed [MSG_W-1:0] in_m [NREG];
  logic signed [SUM_W-1:0] in_acc;

  always_comb begin
    case (deg_sel)
      2'd0:    live_cnt = LIVE_D2;
      2'd1:    live_cnt = LIVE_D4;
      default: live_cnt = NREG;
    endcase
    in_acc = '0;
    for (int i = 0; i < NREG; i++) begin
      in_m[i] = (i < live_cnt) ? $signed(reg_msgs[i*MSG_W +: MSG_W]) : '0;
      in_acc  = in_acc + SUM_W'(in_m[i]);
    end
  end

  logic                    s1_valid;
  logic                    s1_nornd;
  logic [NREG-1:0]         s1_live;
  logic signed [MSG_W-1:0] s1_intr;
  logic signed [MSG_W-1:0] s1_m [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_nornd <= 1'b0;
      s1_live  <= '0;
      s1_intr  <= '0;
      reg_sum  <= '0;
      for (int i = 0; i < NREG; i++) s1_m[i] <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_nornd <= (deg_sel == 2'd0);
        s1_intr  <= intr;
        reg_sum  <= in_acc;
        for (int i = 0; i < NREG; i++) begin
          s1_m[i]    <= in_m[i];
          s1_live[i] <= (i < live_cnt);
        end
      end
    end
  end

  assign reg_valid = s1_valid;

  logic signed [TW-1:0] total;
  assign total = TW'(s1_intr) + TW'(reg_sum) + (s1_nornd ? '0 : TW'(rnd_sum));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_valid;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic signed [TW-1:0] diff;
    logic signed [MSG_W-1:0] sat;
    assign diff = total - TW'(s1_m[g]);
    assign sat = (diff > HI) ? MSG_W'(HI) : (diff < LO) ? MSG_W'(LO) : MSG_W'(diff);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_msgs[g*MSG_W +: MSG_W] <= '0;
      else if (s1_valid) out_msgs[g*MSG_W +: MSG_W] <= s1_live[g] ? sat : '0;
    end
    assert_sym_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_msgs[g*MSG_W +: MSG_W] != {1'b1, {(MSG_W-1){1'b0}}}));
  end

  logic signed [SUM_W-1:0] pair_sum;
  assign pair_sum = SUM_W'($signed(reg_msgs[0 +: MSG_W])) + SUM_W'($signed(reg_msgs[MSG_W +: MSG_W]));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(reg_valid));
  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));
  assert_regsum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && deg_sel == 2'd0) |=> (reg_valid && reg_sum == $past(pair_sum)));
  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && s1_nornd) |=> (out_msgs[NREG*MSG_W-1:2*MSG_W] == '0));
endmodule

// File: tb/tb_vn_split_update.sv
module tb_vn_split_update;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] deg_sel = 0;
  logic signed [5:0] intr = 0;
  logic [29:0] reg_msgs = 0;
  logic signed [8:0] rnd_sum = 0;
  logic reg_valid, out_valid;
  logic signed [8:0] reg_sum;
  logic [29:0] out_msgs;
  int checks = 0, fails = 0;
  bit done = 0;

  vn_split_update dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .deg_sel(deg_sel),
    .intr(intr), .reg_msgs(reg_msgs), .rnd_sum(rnd_sum), .reg_valid(reg_valid),
    .reg_sum(reg_sum), .out_valid(out_valid), .out_msgs(out_msgs));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nlive(input int d);
    return (d == 0) ? 2 : (d == 1) ? 3 : 5;
  endfunction

  function automatic int satv(input int v);
    return (v > 31) ? 31 : (v < -31) ? -31 : v;
  endfunction

  function automatic int rsum(input int d, input int m[5]);
    int s = 0;
    for (int i = 0; i < nlive(d); i++) s += m[i];
    return s;
  endfunction

  task automatic drive(input int d, input int l, input int m[5]);
    deg_sel = 2'(d);
    intr = 6'(l);
    for (int i = 0; i < 5; i++) reg_msgs[i*6 +: 6] = 6'(m[i]);
  endtask

  task automatic check_out(input string req, input int d, input int l, input int m[5], input int r);
    int tot = l + rsum(d, m) + ((d == 0) ? 0 : r);
    check(out_valid == 1, {req, " out_valid"}, int'(out_valid), 1);
    for (int i = 0; i < 5; i++) begin
      int exp = (i < nlive(d)) ? satv(tot - m[i]) : 0;
      int act = int'($signed(out_msgs[i*6 +: 6]));
      check(act == exp, req, act, exp);
    end
  endtask

  task automatic run_node(input string req, input int d, input int l, input int m[5], input int r);
    @(negedge clk);
    drive(d, l, m);
    in_valid = 1;
    rnd_sum = -9'sd170;
    @(negedge clk);
    in_valid = 0;
    drive(3, -20, '{-31, 25, -17, 9, 13});
    rnd_sum = 9'(r);
    check(reg_valid == 1, "R3 reg_valid", int'(reg_valid), 1);
    check(int'(reg_sum) == rsum(d, m), "R3 reg_sum", int'(reg_sum), rsum(d, m));
    check(out_valid == 0, "R4 early out_valid", int'(out_valid), 0);
    @(negedge clk);
    rnd_sum = 9'sd123;
    check_out(req, d, l, m, r);
    check(reg_valid == 0, "R3 reg_valid drop", int'(reg_valid), 0);
  endtask

  task automatic t_reset();
    #1;
    check(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    check(reg_valid == 0, "R1 reg_valid", int'(reg_valid), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R1 out_valid after release", int'(out_valid), 0);
    check(reg_valid == 0, "R1 reg_valid after release", int'(reg_valid), 0);
  endtask

  task automatic t_stream();
    int ma[5] = '{4, -9, 12, -1, 6};
    int mb[5] = '{-3, 8, 20, 20, 20};
    @(negedge clk);
    drive(2, 7, ma); in_valid = 1; rnd_sum = 9'sd77;
    @(negedge clk);
    check(int'(reg_sum) == rsum(2, ma), "R9 reg_sum A", int'(reg_sum), rsum(2, ma));
    drive(1, -11, mb); rnd_sum = -9'sd5;
    @(negedge clk);
    in_valid = 0;
    check_out("R9 node A", 2, 7, ma, -5);
    check(int'(reg_sum) == rsum(1, mb), "R9 reg_sum B", int'(reg_sum), rsum(1, mb));
    rnd_sum = 9'sd14;
    @(negedge clk);
    check_out("R9 node B", 1, -11, mb, 14);
  endtask

  initial begin
    t_reset();
    run_node("R4 R2 max degree", 2, 5, '{3, -4, 7, 1, -2}, 6);
    run_node("R7 R2 degree four", 1, -3, '{2, 5, -6, 30, -30}, -4);
    run_node("R6 degree two", 0, 4, '{10, -7, 31, 31, 31}, 100);
    run_node("R2 code three", 3, -6, '{1, 2, -3, 4, -5}, 9);
    run_node("R8 positive rail", 2, 31, '{31, 31, 31, 31, 31}, 200);
    run_node("R8 negative rail", 2, -32, '{-32, -32, -32, -32, -32}, -256);
    run_node("R8 minus32 corner", 1, -20, '{0, 0, 12, 0, 0}, -12);
    run_node("R5 sample window", 2, 0, '{1, 1, 1, 1, 1}, -50);
    t_stream();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule